// File: doc/BRIEF.md
# Banked Vector Address Generator

This block turns one vector memory operation into a stream of per-element requests aimed at a memory built from 16 independently timed banks. A start strobe latches a base address, a signed stride, a vector length and an address mode. In constant-stride mode each element's word address is the base plus the element number times the stride. In indexed mode (gather or scatter) the element's word address is the base plus an index value that the surrounding logic supplies for the element number the block presents. The low bits of the word address select a bank, so consecutive words sit in consecutive banks.

Each bank stays busy for a fixed window after it accepts an access. The generator holds an element back while its bank is still busy, and later elements wait behind it, so element order is kept. Unit stride, and strides that share no factor with the bank count, therefore stream at one element per cycle. Strides that keep returning to the same few banks slow down. A valid/ready handshake toward memory sets the pace. A one-cycle done flag marks the end of the operation. A delayed copy of each accepted element number tells the consumer when that element's read data is due back.

Top module: `vec_agen`

## Requirements
- R1: After reset, and at all times until a start is accepted, req_valid, done and ret_valid are 0.
- R2: req_bank is bits [3:0] of the element's 20-bit word address and req_word is bits [19:4]. In constant-stride mode the address of element i is (base + i*stride) modulo 2^20, with stride read as a two's complement number.
- R3: In indexed mode (indexed=1 at start) the address of element i is (base + idx_data) modulo 2^20, where idx_data is the unsigned index the environment returns while elem_idx equals i.
- R4: A bank never accepts two requests fewer than 4 cycles apart. An element whose bank is busy waits, and no later element is issued before it.
- R5: When its bank is free and req_ready is 1, the first element is offered in the cycle after the start is accepted, and each later element in the cycle after the previous acceptance. Unit stride therefore runs at one element per cycle.
- R6: The element counter advances only when req_valid and req_ready are both 1. While req_ready is 0, an offered request keeps req_valid high and keeps its bank and word unchanged.
- R7: An operation issues exactly vlen requests, with elem_idx counting from 0 in order. done is high for one cycle, in the cycle after the last request is accepted, and req_valid is 0 in that cycle.
- R8: A start with vlen of 0 issues no request and raises done in the cycle after the start.
- R9: A start that arrives while an operation is running is ignored, and the running operation's addresses, order and timing do not change.
- R10: ret_valid is high, with ret_tag equal to the element number, exactly 12 cycles after each accepted request, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| indexed | input | 1 | 1 selects indexed mode, 0 constant stride |
| base | input | 20 | Base word address |
| stride | input | 20 | Signed word stride |
| vlen | input | 7 | Number of elements, 0 to 64 |
| idx_data | input | 16 | Index for the element shown on elem_idx |
| elem_idx | output | 7 | Number of the element being offered |
| req_valid | output | 1 | Request offered to memory |
| req_ready | input | 1 | Memory accepts the request |
| req_bank | output | 4 | Target bank |
| req_word | output | 16 | Word address inside the bank |
| ret_valid | output | 1 | Read data for ret_tag is due this cycle |
| ret_tag | output | 7 | Element number of the returning read |
| done | output | 1 | One-cycle end-of-operation flag |

## Verification
The assertions check on every cycle the properties that need no knowledge of the operation: the bank busy window between accepted requests to the same bank, that a request held by low ready keeps its address, that done never coincides with an offer, and that nothing is offered while the block is idle without a start. Exact addresses, the cycle in which each element is accepted under stride patterns that stall, the return timing, zero-length operations and the ignored mid-operation start are shown only by the bench. The bench sweeps many strides and indexed patterns and compares each one against an arithmetic model of bank timing.

// File: rtl/vec_agen.sv
module vec_agen #(
  parameter int ADDR_W = 20,
  parameter int BANKS  = 16,
  parameter int BUSY   = 4,
  parameter int VLEN_W = 7,
  parameter int IDX_W  = 16,
  parameter int LAT    = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         indexed,
  input  logic [ADDR_W-1:0]            base,
  input  logic [ADDR_W-1:0]            stride,
  input  logic [VLEN_W-1:0]            vlen,
  input  logic [IDX_W-1:0]             idx_data,
  output logic [VLEN_W-1:0]            elem_idx,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic [$clog2(BANKS)-1:0]     req_bank,
  output logic [ADDR_W-$clog2(BANKS)-1:0] req_word,
  output logic                         ret_valid,
  output logic [VLEN_W-1:0]            ret_tag,
  output logic                         done
);
  localparam int BANK_W = $clog2(BANKS);
  localparam int BC_W   = $clog2(BUSY);

  logic              active, mode_q;
  logic [ADDR_W-1:0] base_q, stride_q, acc, addr;
  logic [VLEN_W-1:0] vlen_q, cnt;
  logic [BC_W-1:0]   bc [BANKS];
  logic              fire, last;

  assign addr      = mode_q ? base_q + ADDR_W'(idx_data) : acc;
  assign req_bank  = addr[BANK_W-1:0];
  assign req_word  = addr[ADDR_W-1:BANK_W];
  assign req_valid = active && (bc[req_bank] == '0);
  assign fire      = req_valid && req_ready;
  assign elem_idx  = cnt;
  assign last      = (cnt == vlen_q - VLEN_W'(1));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bc[b] <= '0;
      else if (fire && req_bank == BANK_W'(b))
        bc[b] <= BC_W'(BUSY - 1);
      else if (bc[b] != '0)
        bc[b] <= bc[b] - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      mode_q   <= 1'b0;
      base_q   <= '0;
      stride_q <= '0;
      acc      <= '0;
      vlen_q   <= '0;
      cnt      <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !active) begin
        mode_q   <= indexed;
        base_q   <= base;
        stride_q <= stride;
        acc      <= base;
        vlen_q   <= vlen;
        cnt      <= '0;
        active   <= (vlen != '0);
        done     <= (vlen == '0);
      end else if (fire) begin
        cnt <= cnt + 1'b1;
        acc <= acc + stride_q;
        if (last) begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  logic [LAT-1:0]    pv;
  logic [VLEN_W-1:0] pt [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= '0;
    else        pv <= {pv[LAT-2:0], fire};
  end

  always_ff @(posedge clk) begin
    pt[0] <= cnt;
    for (int j = 1; j < LAT; j++) pt[j] <= pt[j-1];
  end

  assign ret_valid = pv[LAT-1];
  assign ret_tag   = pt[LAT-1];
endmodule

module vec_agen_chk #(
  parameter int BANK_W = 4,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              active,
  input logic              req_valid,
  input logic              req_ready,
  input logic [BANK_W-1:0] req_bank,
  input logic [WORD_W-1:0] req_word,
  input logic              done
);
  logic acc_now;
  assign acc_now = req_valid && req_ready;

  // R6
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_bank) && $stable(req_word)));

  // R4
  bank_gap1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_now && $past(acc_now)) |-> (req_bank != $past(req_bank)));

  // R4
  bank_gap2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_now && $past(acc_now, 2)) |-> (req_bank != $past(req_bank, 2)));

  // R4
  bank_gap3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_now && $past(acc_now, 3)) |-> (req_bank != $past(req_bank, 3)));

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> !req_valid);
endmodule

bind vec_agen vec_agen_chk #(.BANK_W(BANK_W), .WORD_W(ADDR_W - BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .active(active),
  .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
  .req_word(req_word), .done(done)
);

// File: tb/sim_vec_agen.sv
`timescale 1ns/1ps
module sim_vec_agen;
  localparam int MASK = 32'hFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        indexed = 1'b0;
  logic [19:0] base = '0;
  logic [19:0] stride = '0;
  logic [6:0]  vlen = '0;
  logic [15:0] idx_data;
  logic [6:0]  elem_idx;
  logic        req_valid;
  logic        req_ready = 1'b1;
  logic [3:0]  req_bank;
  logic [15:0] req_word;
  logic        ret_valid;
  logic [6:0]  ret_tag;
  logic        done;

  always #2 clk = ~clk;

  int idx_mem [64];
  assign idx_data = 16'(idx_mem[elem_idx[5:0]]);

  vec_agen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .indexed(indexed), .base(base),
    .stride(stride), .vlen(vlen), .idx_data(idx_data), .elem_idx(elem_idx),
    .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
    .req_word(req_word), .ret_valid(ret_valid), .ret_tag(ret_tag), .done(done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int n = 0, k = 0, s = 0, exp_done = 0, pat = 0;
  bit got_done = 0;
  int eb [64], ew [64], et [64];
  bit hv [32];
  int ht [32];

  function automatic bit rdy(int c);
    return (pat == 0) ? 1'b1 : ((c % 3) != 0);
  endfunction

  always @(posedge clk) begin
    #1;
    req_ready = rdy(cyc);
  end

  task automatic fail(string req, int act, int exp);
    errors++;
    $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (cyc >= 12) begin
        bit ev;
        ev = hv[(cyc - 12) % 32];
        if (ev || ret_valid) begin
          checks++; // R10
          if (ret_valid !== ev) fail("R10 ret_valid", int'(ret_valid), int'(ev));
          else if (int'(ret_tag) != ht[(cyc - 12) % 32]) fail("R10 ret_tag", int'(ret_tag), ht[(cyc - 12) % 32]);
        end
      end
      hv[cyc % 32] = req_valid && req_ready;
      ht[cyc % 32] = int'(elem_idx);
      if (req_valid && req_ready) begin
        if (k < n) begin
          checks++; // R2 R3 R4 R5 R6
          if (int'(req_bank) != eb[k]) fail("R2/R3 bank", int'(req_bank), eb[k]);
          else if (int'(req_word) != ew[k]) fail("R2/R3 word", int'(req_word), ew[k]);
          else if (int'(elem_idx) != k) fail("R7 order", int'(elem_idx), k);
          else if (cyc != s + et[k]) fail("R4/R5 timing", cyc - s, et[k]);
          k++;
        end else begin
          checks++;
          fail("R7 extra request", k + 1, n);
        end
      end
      if (done) begin
        got_done = 1;
        checks++; // R7 R8
        if (cyc != exp_done) fail("R7/R8 done cycle", cyc - s, exp_done - s);
        else if (k != n) fail("R7 request count", k, n);
      end
    end
  end

  task automatic run_op(bit ind, int b, int st, int vl, int p, bit poke);
    int last_use [16];
    int prev, e, a, bk;
    @(posedge clk);
    #1;
    pat = p;
    indexed = ind;
    base = b[19:0];
    stride = st[19:0];
    vlen = vl[6:0];
    start = 1'b1;
    s = cyc + 1;
    for (int i = 0; i < 16; i++) last_use[i] = -100;
    prev = -1;
    for (int i = 0; i < vl; i++) begin
      a = ind ? ((b + idx_mem[i]) & MASK) : ((b + i * st) & MASK);
      bk = a & 15;
      e = prev + 1;
      if (e < last_use[bk] + 4) e = last_use[bk] + 4;
      while (!rdy(s + e)) e++;
      eb[i] = bk;
      ew[i] = a >>> 4;
      et[i] = e;
      last_use[bk] = e;
      prev = e;
    end
    exp_done = (vl == 0) ? s : s + et[vl-1] + 1;
    n = vl;
    k = 0;
    got_done = 0;
    @(posedge clk);
    #1;
    start = 1'b0;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1;
      base = 20'h5A5A5;
      stride = 20'd1;
      indexed = ~ind;
      vlen = 7'd3;
      start = 1'b1; // R9: must be ignored
      @(posedge clk);
      #1;
      start = 1'b0;
    end
    for (int t = 0; t < 700; t++) begin
      if (got_done) break;
      @(posedge clk);
    end
    repeat (8) @(posedge clk);
    checks++; // R7
    if (!got_done) fail("R7 done missing", 0, 1);
    else if (k != n) fail("R7 total requests", k, n);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++)
      idx_mem[i] = (i % 5 == 0) ? 16 * i : ((i * 37 + i * i * 11) & 16'hFFFF);
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    checks++; // R1
    if (req_valid !== 1'b0 || done !== 1'b0 || ret_valid !== 1'b0)
      fail("R1 reset outputs", int'({req_valid, done, ret_valid}), 0);
    repeat (4) @(negedge clk);
    checks++; // R1
    if (req_valid !== 1'b0 || done !== 1'b0)
      fail("R1 idle outputs", int'({req_valid, done}), 0);

    run_op(0, 20'h00010, 1, 64, 0, 0);      // R5 unit stride full length
    run_op(0, 20'h00003, 16, 8, 0, 0);      // R4 same bank every element
    run_op(0, 20'h00100, 8, 10, 0, 0);      // R4 two banks alternating
    run_op(0, 20'h00005, -1, 17, 0, 0);     // R2 negative stride, wrap
    run_op(0, 20'hFFFF0, 3, 20, 0, 0);      // R2 address wrap
    run_op(0, 20'h00020, 0, 0, 0, 0);       // R8 zero length
    run_op(0, 20'h00020, 2, 0, 0, 0);       // R8 zero length again
    run_op(1, 20'h01000, 0, 40, 0, 0);      // R3 indexed gather
    run_op(1, 20'hFF000, 0, 64, 1, 0);      // R3 R6 indexed with back-pressure
    run_op(0, 20'h00007, 2, 30, 1, 0);      // R6 back-pressure
    run_op(0, 20'h00040, 16, 8, 0, 1);      // R9 start while running
    run_op(1, 20'h00200, 0, 12, 0, 1);      // R9 indexed, start while running
    run_op(0, 20'h00001, 1, 1, 0, 0);       // R7 single element
    for (int st = 0; st < 34; st++)
      run_op(0, st * 7 + 3, st, 16, st % 2, 0);
    for (int st = -9; st < 0; st++)
      run_op(0, 20'h00400, st, 24, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule